// File: doc/BRIEF.md
# Protected watchdog timer controller

This block is a watchdog timer with a single 8-bit control register on a plain synchronous register port. The port has a write strobe, write data and a continuously driven read value. A 3-bit timeout selector picks one of eight timeout lengths. Each length is counted in strobes of a separate tick-enable input. Software keeps the system alive by pulsing a kick input. If the count reaches the selected length while the watchdog is enabled, the block raises a single-cycle reset request.

Turning the watchdog off and changing its timeout are both protected by an unlock bit. A write sets the unlock bit, and the block withdraws it on its own four clock cycles later. A static lock input keeps the watchdog running no matter what software writes. Turning the watchdog on is never protected.

Top module: `wdt_guard`

## Requirements
- R1: After a synchronous active-low reset, the read value is 0x00 and the reset request is low.
- R2: The read value is laid out as follows. Bits 7..5 always read 0. Bit 4 is the unlock bit. Bit 3 is the enable bit. Bits 2..0 are the timeout selector.
- R3: A write with bit 4 set makes the unlock bit read 1 for exactly four cycles after the write edge. The block then clears it without any write.
- R4: A further write with bit 4 set while unlocked restarts the four-cycle window. Writing 0 to bit 4 does not clear the unlock bit early.
- R5: A write with bit 3 set always enables the watchdog.
- R6: A write with bit 3 clear disables the watchdog only if the unlock bit reads 1 in the cycle of that write. A disable write landing on the fourth edge after the unlock write succeeds, and one landing on the fifth edge is ignored.
- R7: Writes to bits 2..0 take effect only if the unlock bit reads 1 in the cycle of the write.
- R8: While the lock input is high, no write can disable the watchdog, even after a correct unlock sequence.
- R9: While enabled, the reset request pulses high for one cycle after 16384·2^sel ticks have been counted. Sel runs 0..7, so the lengths go from 16384 to 2097152 ticks. Counting then restarts from zero.
- R10: A kick, or any write with bit 3 set, restarts the count. While disabled the count is held at zero and no request is made.
- R11: The count advances only in cycles where the tick-enable input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| tick_en | input | 1 | Watchdog tick strobe, one count per high cycle |
| kick | input | 1 | Restart the count |
| safety_lock | input | 1 | Keeps the watchdog from being disabled |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Every register field is visible in the read value in the cycle after the edge that accepts a write. A reset request appears in the cycle after the edge that counts the final tick. The bench drives inputs on falling edges and keeps a behavioural model that is advanced on each rising edge. Fields and the request are compared against that model at the following falling edge. Directed checks count rising edges from the accepting write or kick edge to the request edge and compare that count with 16384·2^sel ticks. Unlock-window checks place the disable write on exactly the fourth and fifth edges after the unlock write.

// File: rtl/wdg_pkg.sv
// Shared constants for the protected watchdog.
// Assumes an 8-bit control register whose bit positions are fixed below.
package wdg_pkg;
    localparam int REG_W    = 8;
    localparam int SEL_W    = 3;
    localparam int UNLK_BIT = 4;
    localparam int ENA_BIT  = 3;

    typedef struct packed {
        logic             unlk;
        logic             ena;
        logic [SEL_W-1:0] sel;
    } wdg_cfg_t;
endpackage

// File: rtl/wdg_ctrl_reg.sv
// Control register with a self-expiring unlock window.
// Assumes the write data is sampled on the same edge as the write strobe.
// Disable and selector writes are honoured only while the unlock bit is set.
module wdg_ctrl_reg
    import wdg_pkg::*;
#(
    parameter int HOLD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [4:0]       wdata,
    input  logic             safety_lock,
    output wdg_cfg_t         cfg,
    output logic             ena_wr
);
    localparam int WIN_W = $clog2(HOLD + 1);
    localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(HOLD - 1);

    logic [WIN_W-1:0] win_q;
    logic             set_unlk;

    assign set_unlk = we && wdata[UNLK_BIT];
    assign ena_wr   = we && wdata[ENA_BIT];

    // Unlock bit: set by a write, withdrawn when the window runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.unlk <= 1'b0;
            win_q    <= '0;
        end else if (set_unlk) begin
            cfg.unlk <= 1'b1;
            win_q    <= WIN_LOAD;
        end else if (cfg.unlk) begin
            if (win_q == '0) cfg.unlk <= 1'b0;
            else             win_q    <= win_q - 1'b1;
        end
    end

    // Enable bit: setting is free, clearing needs unlock and no lock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg.ena <= 1'b0;
        else if (ena_wr)
            cfg.ena <= 1'b1;
        else if (we && cfg.unlk && !safety_lock)
            cfg.ena <= 1'b0;
    end

    // Timeout selector: only written while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg.sel <= '0;
        else if (we && cfg.unlk)
            cfg.sel <= wdata[SEL_W-1:0];
    end

    a_r6_off_needs_unlock : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg.ena) |-> $past(cfg.unlk));
    a_r8_lock_holds_on : assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.ena && safety_lock) |=> cfg.ena);
    a_r7_sel_frozen : assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.unlk |=> $stable(cfg.sel));
    a_r3_window_ends : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg.unlk) |-> (win_q == WIN_LOAD));
endmodule

// File: rtl/wdg_limit.sv
// Turns the timeout selector into the last count value before expiry.
// Assumes the length is 2^(BASE_LOG2 + sel) and that it fits in CNT_W+1 bits.
module wdg_limit
    import wdg_pkg::*;
#(
    parameter int BASE_LOG2 = 14,
    parameter int CNT_W     = 21
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] last
);
    logic [CNT_W:0] span;

    // Length is a power of two; the last count is one below it.
    always_comb begin
        span = (CNT_W+1)'(1) << (BASE_LOG2 + int'(sel));
        last = CNT_W'(span - 1'b1);
    end
endmodule

// File: rtl/wdg_tick_cnt.sv
// Tick counter with expiry detection and a registered reset-request pulse.
// Assumes 'last' is stable while counting and that 'clr' has priority over ticks.
module wdg_tick_cnt #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ena,
    input  logic             clr,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] last,
    output logic             req
);
    logic [CNT_W-1:0] cnt_q;

    // Count ticks while enabled; wrap and request at the selected length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            req   <= 1'b0;
        end else begin
            req <= 1'b0;
            if (!ena || clr) begin
                cnt_q <= '0;
            end else if (tick_en) begin
                if (cnt_q >= last) begin
                    cnt_q <= '0;
                    req   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    a_r9_pulse_single : assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
    a_r10_off_no_req : assert property (@(posedge clk) disable iff (!rst_n)
        !ena |=> !req);
    a_r11_idle_no_req : assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> !req);
endmodule

// File: rtl/wdt_guard.sv
// Top of the protected watchdog: register, limit decode and tick counter.
// Assumes a synchronous active-low reset and a tick strobe in the clk domain.
module wdt_guard
    import wdg_pkg::*;
#(
    parameter int BASE_LOG2 = 14,
    parameter int HOLD      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             tick_en,
    input  logic             kick,
    input  logic             safety_lock,
    output logic             rst_req
);
    localparam int CNT_W = BASE_LOG2 + (1 << SEL_W) - 1;

    wdg_cfg_t         cfg;
    logic             ena_wr;
    logic [CNT_W-1:0] last;
    logic             unused_hi;

    assign unused_hi = ^reg_wdata[REG_W-1:5];

    wdg_ctrl_reg #(.HOLD(HOLD)) u_reg (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata[4:0]),
        .safety_lock(safety_lock), .cfg(cfg), .ena_wr(ena_wr)
    );

    wdg_limit #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_lim (
        .sel(cfg.sel), .last(last)
    );

    wdg_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ena(cfg.ena), .clr(kick || ena_wr),
        .tick_en(tick_en), .last(last), .req(rst_req)
    );

    // Read value: reserved bits zero above the packed configuration.
    assign reg_rdata = {{(REG_W-5){1'b0}}, cfg};
endmodule

// File: tb/tb_wdt_guard.sv
module tb_wdt_guard;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       reg_we = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       tick_en = 0, kick = 0, safety_lock = 0;
    logic       rst_req;

    int tests = 0, fails = 0, cyc = 0, wr_cyc = 0;
    int m_ce = 0, m_win = 0, m_en = 0, m_ps = 0, m_cnt = 0, m_req = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wdt_guard dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tick_en(tick_en), .kick(kick),
        .safety_lock(safety_lock), .rst_req(rst_req));

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        int n_ce, n_win, n_en, n_ps, n_cnt, n_req, span;
        cyc++;
        if (!rst_n) begin
            m_ce = 0; m_win = 0; m_en = 0; m_ps = 0; m_cnt = 0; m_req = 0;
        end else begin
            n_ce = m_ce; n_win = m_win; n_en = m_en; n_ps = m_ps; n_cnt = m_cnt; n_req = 0;
            if (reg_we && reg_wdata[4]) begin n_ce = 1; n_win = 3; end
            else if (m_ce == 1) begin
                if (m_win == 0) n_ce = 0; else n_win = m_win - 1;
            end
            if (reg_we) begin
                if (reg_wdata[3]) n_en = 1;
                else if (m_ce == 1 && !safety_lock) n_en = 0;
                if (m_ce == 1) n_ps = int'(reg_wdata[2:0]);
            end
            span = 16384 * (2 ** m_ps);
            if (m_en == 0) n_cnt = 0;
            else if (kick || (reg_we && reg_wdata[3])) n_cnt = 0;
            else if (tick_en) begin
                if (m_cnt + 1 >= span) begin n_cnt = 0; n_req = 1; end
                else n_cnt = m_cnt + 1;
            end
            m_ce = n_ce; m_win = n_win; m_en = n_en; m_ps = n_ps; m_cnt = n_cnt; m_req = n_req;
        end
    end

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 reserved", int'(reg_rdata[7:5]), 0);
            chk("R3 unlock", int'(reg_rdata[4]), m_ce);
            chk("R6 enable", int'(reg_rdata[3]), m_en);
            chk("R7 selector", int'(reg_rdata[2:0]), m_ps);
            chk("R9 request", int'(rst_req), m_req);
        end
        if (cyc > 195000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 195000);
            finish_run();
        end
    end

    // Call at a falling edge; the write lands on the next rising edge.
    task automatic wr(logic [7:0] v);
        reg_we = 1; reg_wdata = v;
        @(negedge clk);
        reg_we = 0; reg_wdata = 0;
        wr_cyc = cyc;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_req(output int at);
        at = -1;
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk);
            if (rst_req) begin at = cyc; break; end
        end
    endtask

    initial begin
        int at, prev, seen;
        idle(3);
        chk("R1 reset read", int'(reg_rdata), 0);
        chk("R1 reset request", int'(rst_req), 0);
        rst_n = 1;
        @(negedge clk);

        wr(8'h08);
        chk("R5 enable set", int'(reg_rdata), 8'h08);
        wr(8'hE7);
        chk("R7 selector locked", int'(reg_rdata), 8'h08);
        wr(8'h00);
        chk("R6 disable without unlock", int'(reg_rdata[3]), 1);

        wr(8'h18);
        chk("R3 unlock first cycle", int'(reg_rdata[4]), 1);
        idle(3);
        chk("R3 unlock fourth cycle", int'(reg_rdata[4]), 1);
        idle(1);
        chk("R3 unlock expired", int'(reg_rdata[4]), 0);
        wr(8'h00);
        chk("R6 late disable ignored", int'(reg_rdata[3]), 1);

        wr(8'h18); idle(3); wr(8'h00);
        chk("R6 disable on fourth edge", int'(reg_rdata), 0);

        wr(8'h18); idle(2); wr(8'h18); idle(3); wr(8'h00);
        chk("R4 window restarted", int'(reg_rdata[3]), 0);
        wr(8'h18); wr(8'h08);
        chk("R4 zero write keeps unlock", int'(reg_rdata[4]), 1);
        idle(4);

        wr(8'h18); wr(8'h0D);
        chk("R7 selector written", int'(reg_rdata[2:0]), 5);
        wr(8'h18); wr(8'h08);
        chk("R7 selector back to zero", int'(reg_rdata[2:0]), 0);
        idle(4);

        tick_en = 1;
        wr(8'h08);
        wait_req(at);
        chk("R9 timeout sel0", at - wr_cyc, 16384);
        @(negedge clk);
        chk("R9 single pulse", int'(rst_req), 0);
        prev = at;
        wait_req(at);
        chk("R9 restart after expiry", at - prev, 16384);

        tick_en = 0;
        wr(8'h08);
        for (int i = 0; i < 40000; i++) begin
            tick_en = (i % 2 == 0);
            @(negedge clk);
            if (rst_req) begin at = cyc; break; end
        end
        tick_en = 0;
        chk("R11 half-rate ticks", at - wr_cyc, 32767);

        tick_en = 1;
        wr(8'h08);
        idle(9999);
        kick = 1; @(negedge clk); kick = 0;
        prev = cyc;
        wait_req(at);
        chk("R10 kick restarts", at - prev, 16384);

        wr(8'h18); idle(1); wr(8'h00);
        seen = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (rst_req) seen++;
        end
        chk("R10 disabled no request", seen, 0);

        wr(8'h18); wr(8'h09);
        wait_req(at);
        chk("R9 timeout sel1", at - wr_cyc, 32768);
        tick_en = 0;
        idle(2);

        safety_lock = 1;
        wr(8'h18); idle(1); wr(8'h00);
        chk("R8 lock blocks disable", int'(reg_rdata[3]), 1);
        safety_lock = 0;
        idle(5);

        done = 1;
        finish_run();
    end
endmodule